// File: doc/BRIEF.md
# Coin Slot Vend Evaluator

This block decides, on each clock, whether a vend request is granted. Coins sit in a fixed set of slots: three dime slots, two quarter slots and one nickel slot. Each slot raises a presence flag. The block reads these flags and checks that each coin kind was loaded in slot order. It counts the coins against the limit for the selected price, adds up their value, and compares the total with one of three prices picked by a 2-bit select.

While the request input is high, the block drives a registered verdict. Accept means the money is enough, and Change is added when there is more than enough. Reject means the money is short, or the slot pattern is not legal. With the request low, all three outputs are low. Coin handling, the return of change and any counting of coins over time belong to the logic around this block.

Top module: `vend_decider`

## Requirements
- R1: While `rst` is high at a rising clock edge, `accept_o`, `change_o` and `reject_o` are all 0 at the following edge, whatever the other inputs are.
- R2: `price_sel_i` sets the price. 2'b00 is 35 cents, 2'b01 is 45 cents and 2'b10 is 55 cents. A dime is worth 10 cents, a quarter 25 and the nickel 5.
- R3: Slots of one kind fill from bit 0 upward. A set bit in `dime_slot_i[k]` or `quarter_slot_i[k]` with bit k-1 clear is a misordered pattern, and a request with such a pattern gives Reject only.
- R4: At most 3 coins may be counted at 35 and 45 cents, and at most 4 at 55 cents. A request that exceeds the limit gives Reject only.
- R5: `nickel_slot_i` has no effect on the value, the coin count or the outputs unless 55 cents is selected.
- R6: A legal request whose total is equal to the price gives Accept alone.
- R7: A legal request whose total is above the price gives Accept and Change together.
- R8: A legal request with a total below the price, including no coins at all, gives Reject only.
- R9: The outputs are registered: they show the inputs sampled at the previous rising edge. They are all 0 if `req_i` was 0 at that edge.
- R10: `price_sel_i` = 2'b11 is reserved, and a request with that value gives Reject only.
- R11: Accept and Reject are never high together, and Change never appears without Accept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Vend request button |
| dime_slot_i | input | 3 | Dime slot presence flags, bit 0 fills first |
| quarter_slot_i | input | 2 | Quarter slot presence flags, bit 0 fills first |
| nickel_slot_i | input | 1 | Nickel slot presence flag |
| price_sel_i | input | 2 | Price select |
| accept_o | output | 1 | Vend granted |
| change_o | output | 1 | Money above price |
| reject_o | output | 1 | Vend refused |

## Verification
Accept and Change rise in the same cycle whenever a legal pattern holds more than the price. The bench provokes this with patterns such as two quarters and a dime at 55 cents, and with a sweep over every slot pattern and price. In the same cycle a misordered or over-limit pattern can hold enough money to pass the price. Here the ordering and count checks must win, so that only Reject rises. A behavioural model, written with integer cents and coin counts, judges each cycle and compares the three outputs with the values it computes.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam int VAL_W = 8;

  typedef enum logic [1:0] {
    PRICE_LOW  = 2'b00,
    PRICE_MID  = 2'b01,
    PRICE_HIGH = 2'b10,
    PRICE_RSV  = 2'b11
  } price_sel_e;

  typedef struct packed {
    logic accept;
    logic change;
    logic reject;
  } verdict_t;

endpackage

// File: rtl/slot_tally.sv
module slot_tally #(
  parameter int N_SLOTS  = 3,
  parameter int COIN_VAL = 10,
  parameter int VAL_W    = 8
) (
  input  logic [N_SLOTS-1:0] slots_i,
  output logic               ordered_o,
  output logic [VAL_W-1:0]   count_o,
  output logic [VAL_W-1:0]   value_o
);

  logic [N_SLOTS-1:0] link_ok;

  assign link_ok[0] = 1'b1;

  genvar g;
  generate
    for (g = 1; g < N_SLOTS; g++) begin : g_link
      // a slot may hold a coin only if the one below it does
      assign link_ok[g] = !slots_i[g] || slots_i[g-1];
    end
  endgenerate

  assign ordered_o = &link_ok;

  always_comb begin
    count_o = '0;
    value_o = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (slots_i[i]) begin
        count_o = count_o + VAL_W'(1);
        value_o = value_o + VAL_W'(COIN_VAL);
      end
    end
  end

endmodule

// File: rtl/price_rule.sv
module price_rule
  import vend_pkg::*;
#(
  parameter int PRICE_A  = 35,
  parameter int PRICE_B  = 45,
  parameter int PRICE_C  = 55,
  parameter int MAX_AB   = 3,
  parameter int MAX_C    = 4,
  parameter int VAL_W    = 8
) (
  input  logic [1:0]       sel_i,
  output logic [VAL_W-1:0] price_o,
  output logic [VAL_W-1:0] max_coins_o,
  output logic             nickel_en_o,
  output logic             sel_valid_o
);

  always_comb begin
    price_o     = VAL_W'(PRICE_A);
    max_coins_o = VAL_W'(MAX_AB);
    nickel_en_o = 1'b0;
    sel_valid_o = 1'b1;
    unique case (price_sel_e'(sel_i))
      PRICE_LOW: ;
      PRICE_MID: price_o = VAL_W'(PRICE_B);
      PRICE_HIGH: begin
        price_o     = VAL_W'(PRICE_C);
        max_coins_o = VAL_W'(MAX_C);
        nickel_en_o = 1'b1;
      end
      PRICE_RSV: sel_valid_o = 1'b0;
      default:   sel_valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/vend_compare.sv
module vend_compare
  import vend_pkg::*;
#(
  parameter int VAL_W = 8
) (
  input  logic             req_i,
  input  logic             ordered_i,
  input  logic             sel_valid_i,
  input  logic [VAL_W-1:0] coins_i,
  input  logic [VAL_W-1:0] max_coins_i,
  input  logic [VAL_W-1:0] total_i,
  input  logic [VAL_W-1:0] price_i,
  output verdict_t         verdict_o
);

  logic legal;
  logic enough;

  assign legal  = ordered_i && sel_valid_i && (coins_i <= max_coins_i);
  assign enough = legal && (total_i >= price_i);

  always_comb begin
    verdict_o = '0;
    if (req_i) begin
      verdict_o.accept = enough;
      verdict_o.change = enough && (total_i > price_i);
      verdict_o.reject = !enough;
    end
  end

endmodule

// File: rtl/vend_decider.sv
module vend_decider
  import vend_pkg::*;
#(
  parameter int N_DIME    = 3,
  parameter int N_QUARTER = 2,
  parameter int DIME_VAL  = 10,
  parameter int QTR_VAL   = 25,
  parameter int NICK_VAL  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_i,
  input  logic [N_DIME-1:0]    dime_slot_i,
  input  logic [N_QUARTER-1:0] quarter_slot_i,
  input  logic                 nickel_slot_i,
  input  logic [1:0]           price_sel_i,
  output logic                 accept_o,
  output logic                 change_o,
  output logic                 reject_o
);

  localparam int W = VAL_W;

  logic [W-1:0] price, max_coins;
  logic         nickel_en, sel_valid;
  logic         dime_ok, qtr_ok, nick_ok;
  logic [W-1:0] dime_cnt, qtr_cnt, nick_cnt;
  logic [W-1:0] dime_val, qtr_val, nick_val;
  logic [W-1:0] coins_sum, value_sum;
  logic [0:0]   nick_gated;
  verdict_t     verdict_d, verdict_q;

  price_rule #(.VAL_W(W)) u_price (
    .sel_i       (price_sel_i),
    .price_o     (price),
    .max_coins_o (max_coins),
    .nickel_en_o (nickel_en),
    .sel_valid_o (sel_valid)
  );

  slot_tally #(.N_SLOTS(N_DIME), .COIN_VAL(DIME_VAL), .VAL_W(W)) u_dime (
    .slots_i   (dime_slot_i),
    .ordered_o (dime_ok),
    .count_o   (dime_cnt),
    .value_o   (dime_val)
  );

  slot_tally #(.N_SLOTS(N_QUARTER), .COIN_VAL(QTR_VAL), .VAL_W(W)) u_qtr (
    .slots_i   (quarter_slot_i),
    .ordered_o (qtr_ok),
    .count_o   (qtr_cnt),
    .value_o   (qtr_val)
  );

  // the nickel only counts when the high price enables it
  assign nick_gated = nickel_slot_i & nickel_en;

  slot_tally #(.N_SLOTS(1), .COIN_VAL(NICK_VAL), .VAL_W(W)) u_nick (
    .slots_i   (nick_gated),
    .ordered_o (nick_ok),
    .count_o   (nick_cnt),
    .value_o   (nick_val)
  );

  assign coins_sum = dime_cnt + qtr_cnt + nick_cnt;
  assign value_sum = dime_val + qtr_val + nick_val;

  vend_compare #(.VAL_W(W)) u_cmp (
    .req_i       (req_i),
    .ordered_i   (dime_ok && qtr_ok && nick_ok),
    .sel_valid_i (sel_valid),
    .coins_i     (coins_sum),
    .max_coins_i (max_coins),
    .total_i     (value_sum),
    .price_i     (price),
    .verdict_o   (verdict_d)
  );

  always_ff @(posedge clk) begin
    if (rst) verdict_q <= '0;
    else     verdict_q <= verdict_d;
  end

  assign accept_o = verdict_q.accept;
  assign change_o = verdict_q.change;
  assign reject_o = verdict_q.reject;

endmodule

// File: rtl/vend_checker.sv
module vend_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_i,
  input logic [2:0] dime_slot_i,
  input logic [1:0] quarter_slot_i,
  input logic [1:0] price_sel_i,
  input logic       accept_o,
  input logic       change_o,
  input logic       reject_o
);

  p_no_accept_reject_r11: assert property (@(posedge clk) disable iff (rst)
    !(accept_o && reject_o));

  p_change_needs_accept_r11: assert property (@(posedge clk) disable iff (rst)
    change_o |-> accept_o);

  p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!accept_o && !change_o && !reject_o));

  p_one_verdict_r9: assert property (@(posedge clk) disable iff (rst)
    req_i |=> (accept_o != reject_o));

  p_misorder_r3: assert property (@(posedge clk) disable iff (rst)
    (req_i && ((dime_slot_i[1] && !dime_slot_i[0]) || (dime_slot_i[2] && !dime_slot_i[1])
               || (quarter_slot_i[1] && !quarter_slot_i[0]))) |=> reject_o);

  p_reserved_sel_r10: assert property (@(posedge clk) disable iff (rst)
    (req_i && price_sel_i == 2'b11) |=> (reject_o && !accept_o));

endmodule

bind vend_decider vend_checker chk_i (
  .clk            (clk),
  .rst            (rst),
  .req_i          (req_i),
  .dime_slot_i    (dime_slot_i),
  .quarter_slot_i (quarter_slot_i),
  .price_sel_i    (price_sel_i),
  .accept_o       (accept_o),
  .change_o       (change_o),
  .reject_o       (reject_o)
);

// File: tb/vend_decider_tb_top.sv
module vend_decider_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       req;
  logic [2:0] dime;
  logic [1:0] qtr;
  logic       nick;
  logic [1:0] sel;
  logic       acc, chg, rej;

  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk;

  vend_decider dut_i (
    .clk            (clk),
    .rst            (rst),
    .req_i          (req),
    .dime_slot_i    (dime),
    .quarter_slot_i (qtr),
    .nickel_slot_i  (nick),
    .price_sel_i    (sel),
    .accept_o       (acc),
    .change_o       (chg),
    .reject_o       (rej)
  );

  function automatic int ones(input int v);
    int c = 0;
    for (int b = 0; b < 8; b++) if (v[b]) c++;
    return c;
  endfunction

  // behavioural model: integer cents and coin counts
  function automatic void model(input logic rq, input logic [2:0] d, input logic [1:0] q,
                                input logic n, input logic [1:0] s,
                                output logic [2:0] e, output string tag);
    int price, maxc, coins, cents, nk;
    bit ordered;
    e = 3'b000;
    if (!rq)   begin tag = "R9";  return; end
    if (s == 2'b11) begin e = 3'b001; tag = "R10"; return; end
    price   = (s == 2'b00) ? 35 : (s == 2'b01) ? 45 : 55;
    maxc    = (s == 2'b10) ? 4 : 3;
    nk      = (s == 2'b10 && n) ? 1 : 0;
    ordered = (d == 3'b000 || d == 3'b001 || d == 3'b011 || d == 3'b111) &&
              (q == 2'b00 || q == 2'b01 || q == 2'b11);
    coins   = ones(int'(d)) + ones(int'(q)) + nk;
    cents   = 10 * ones(int'(d)) + 25 * ones(int'(q)) + 5 * nk;
    if (!ordered)            begin e = 3'b001; tag = "R3"; end
    else if (coins > maxc)   begin e = 3'b001; tag = "R4"; end
    else if (cents > price)  begin e = 3'b110; tag = "R7"; end
    else if (cents == price) begin e = 3'b100; tag = "R6"; end
    else                     begin e = 3'b001; tag = "R8"; end
    if (s != 2'b10 && n && tag != "R3" && tag != "R4") tag = "R5";
  endfunction

  task automatic step(input logic rq, input logic [2:0] d, input logic [1:0] q,
                      input logic n, input logic [1:0] s, input string force_tag);
    logic [2:0] e;
    string tag;
    req = rq; dime = d; qtr = q; nick = n; sel = s;
    model(rq, d, q, n, s, e, tag);
    if (force_tag != "") tag = force_tag;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if ({acc, chg, rej} !== e) begin
      failures++;
      $display("FAIL %s: sel=%b d=%b q=%b n=%b req=%b got acc/chg/rej=%b expected=%b",
               tag, s, d, q, n, rq, {acc, chg, rej}, e);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; req = 1'b1; dime = 3'b001; qtr = 2'b01; nick = 1'b0; sel = 2'b00;
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if ({acc, chg, rej} !== 3'b000) begin
      failures++;
      $display("FAIL R1: reset outputs got %b expected 000", {acc, chg, rej});
    end
    rst = 1'b0;

    // R2 / R6: exact price at each select
    step(1, 3'b001, 2'b01, 0, 2'b00, "R2");   // 35 exact
    step(1, 3'b011, 2'b01, 0, 2'b01, "R2");   // 45 exact
    step(1, 3'b000, 2'b11, 1, 2'b10, "R6");   // 55 via nickel, 3 coins
    step(1, 3'b111, 2'b01, 0, 2'b10, "R6");   // 55 with 4 coins
    // R7: accept and change together
    step(1, 3'b001, 2'b11, 0, 2'b10, "R7");   // 60 at 55
    step(1, 3'b000, 2'b11, 0, 2'b00, "R7");   // 50 at 35
    // R8: short and empty
    step(1, 3'b000, 2'b00, 0, 2'b00, "R8");
    step(1, 3'b011, 2'b00, 0, 2'b01, "R8");
    // R3: misordered with enough money
    step(1, 3'b010, 2'b11, 0, 2'b00, "R3");
    step(1, 3'b001, 2'b10, 0, 2'b00, "R3");
    // R4: too many coins though money suffices
    step(1, 3'b011, 2'b11, 0, 2'b00, "R4");
    step(1, 3'b011, 2'b11, 1, 2'b10, "R4");
    // R5: nickel ignored at 35 (30+5 would pass if counted, count 4 would fail)
    step(1, 3'b111, 2'b00, 1, 2'b00, "R5");
    step(1, 3'b011, 2'b01, 1, 2'b00, "R5");
    // R10: reserved select
    step(1, 3'b001, 2'b11, 0, 2'b11, "R10");
    // R9: request dropped
    step(0, 3'b001, 2'b11, 0, 2'b10, "R9");
    step(1, 3'b001, 2'b01, 0, 2'b00, "R9");
    step(0, 3'b001, 2'b01, 0, 2'b00, "R9");

    // full sweep, R11 exclusivity judged by the model's exact verdict
    for (int v = 0; v < 512; v++) begin
      step(v[8], v[2:0], v[4:3], v[5], v[7:6], "");
    end
    finish_run();
  end

endmodule